// File: doc/BRIEF.md
# Table-Driven Register Init Sequencer

After reset, this block programs a set of peripheral registers from a configuration table held in a read-only memory. A start pulse gives the table's 16-bit byte offset and its 16-bit byte size. The sequencer then walks the table one eight-byte entry at a time until every whole entry has been processed.

Each entry is two 32-bit words. The ROM already presents each word as a little-endian assembled value. The first word is either a register offset or a command code, and the second word carries the operands.

- A register entry performs a read-modify-write on the low 16 bits of the addressed register.
- A timed-wait command idles for a number of microseconds.
- A ready-wait command stalls until the memory controller reports that its initialisation is done.
- Unknown command codes are skipped and recorded in a sticky error flag.

The control is a single state machine with these states:

- `S_IDLE`: waits for start.
- `S_FETCH_OFS`: reads the first word.
- `S_FETCH_ARG`: reads the second word and latches the first.
- `S_DECODE`: classifies the entry and issues the register read or loads the timer.
- `S_WRITE`: writes the merged value.
- `S_WAIT_US`: counts down the timed wait.
- `S_WAIT_RDY`: waits for `mem_ready`.
- `S_ADVANCE`: steps to the next entry, or finishes.

The transitions are:

- `S_IDLE` goes to `S_FETCH_OFS` on a start with at least one entry.
- `S_FETCH_OFS` goes to `S_FETCH_ARG`, which goes to `S_DECODE`.
- `S_DECODE` goes to `S_WRITE` for a register entry, to `S_WAIT_US` for a nonzero timed wait, and to `S_WAIT_RDY` for a ready wait. It goes to `S_ADVANCE` for a zero wait or an unknown code.
- `S_WRITE` goes to `S_ADVANCE`.
- `S_WAIT_US` goes to `S_ADVANCE` on its last count.
- `S_WAIT_RDY` goes to `S_ADVANCE` when `mem_ready` is high.
- `S_ADVANCE` goes to `S_FETCH_OFS` while entries remain, and to `S_IDLE` after the last one.

Top module: `init_seq`

## Requirements
- R1: Entry i is fetched as two ROM words. The first word is at byte address offset+8i and the second at offset+8i+4, with both read requests on consecutive cycles. ROM data arrives one cycle after its request.
- R2: A register entry reads the register (`reg_rd`) and then, on the next cycle, writes it (`reg_wr`) at the same address. The register bus returns read data one cycle after `reg_rd`.
- R3: In the second word, bits 15:0 are the value and bits 31:16 are the mask. The written data is {old[31:16], (old[15:0] & ~mask) | (value & mask)}.
- R4: A first word below 0x00020000 is a register entry, and `reg_addr` is its low 17 bits.
- R5: First word 0x00020000 is a timed wait of operand[15:0] × CYC_PER_US cycles. Operand bits 31:16 are ignored, no bus access occurs during the wait, and an operand of zero adds no wait cycles. An entry with a zero wait takes 4 busy cycles, a register entry takes 5, and a nonzero wait adds N×CYC_PER_US cycles.
- R6: First word 0x00020001 stalls the sequence until `mem_ready` is high.
- R7: A first word of 0x00020002 or above is skipped with no register access, and it sets `err`. `err` stays set until the next accepted start clears it.
- R8: The entry count is size/8, and any remainder bytes are ignored. A size below 8 raises `done` one cycle after start, with no ROM or register access.
- R9: A start while `busy` is ignored.
- R10: `busy` rises the cycle after an accepted start and falls with the cycle that raises `done`. `done` stays high until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| tbl_offset | input | 16 | Table byte offset in ROM |
| tbl_size | input | 16 | Table byte size |
| rom_en | output | 1 | ROM read request |
| rom_addr | output | 16 | ROM byte address |
| rom_rdata | input | 32 | ROM word, valid one cycle after request |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 17 | Register offset |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid one cycle after `reg_rd` |
| mem_ready | input | 1 | Memory controller init-done status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete (held) |
| err | output | 1 | Unknown command seen (sticky) |

## Verification
The assertions check the following on every cycle:

- the pairing of the two ROM reads at consecutive addresses;
- a write always follows a read of the same address;
- the bus is silent when idle;
- `busy` only rises after a start;
- `busy` and `done` are exclusive;
- `done` and `err` hold until a start.

Only the bench's scenarios can show the rest:

- the merged register values for varied masks;
- the exact wait length and the ignored upper operand;
- the stall on `mem_ready`;
- the skip of unknown codes and of remainder bytes;
- that a start during a sequence leaves it untouched.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH_OFS, S_FETCH_ARG, S_DECODE,
        S_WRITE, S_WAIT_US, S_WAIT_RDY, S_ADVANCE
    } state_e;

    typedef enum logic [1:0] {
        K_REG, K_WAIT_US, K_WAIT_RDY, K_UNKNOWN
    } kind_e;

    localparam logic [31:0] CMD_BASE     = 32'h0002_0000;
    localparam logic [31:0] CMD_WAIT_US  = CMD_BASE;
    localparam logic [31:0] CMD_WAIT_RDY = CMD_BASE + 32'd1;
endpackage

// File: rtl/init_seq_decode.sv
module init_seq_decode
    import init_seq_pkg::*;
(
    input  logic [31:0] ofs_word,
    output kind_e       kind
);
    always_comb begin
        if (ofs_word < CMD_BASE)
            kind = K_REG;
        else if (ofs_word == CMD_WAIT_US)
            kind = K_WAIT_US;
        else if (ofs_word == CMD_WAIT_RDY)
            kind = K_WAIT_RDY;
        else
            kind = K_UNKNOWN;
    end
endmodule

// File: rtl/init_seq_merge.sv
module init_seq_merge #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 16
) (
    input  logic [DATA_W-1:0]    old_val,
    input  logic [2*FIELD_W-1:0] arg,
    output logic [DATA_W-1:0]    new_val
);
    logic [FIELD_W-1:0] value;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] low;

    assign value = arg[FIELD_W-1:0];
    assign mask  = arg[2*FIELD_W-1:FIELD_W];
    assign low   = (old_val[FIELD_W-1:0] & ~mask) | (value & mask);

    generate
        if (DATA_W > FIELD_W) begin : g_keep_upper
            assign new_val = {old_val[DATA_W-1:FIELD_W], low};
        end else begin : g_low_only
            assign new_val = low[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/init_seq_timer.sv
module init_seq_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/init_seq.sv
module init_seq
    import init_seq_pkg::*;
#(
    parameter int ROM_AW     = 16,
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 32,
    parameter int CYC_PER_US = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROM_AW-1:0] tbl_offset,
    input  logic [ROM_AW-1:0] tbl_size,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [31:0]       rom_rdata,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int IDX_W = ROM_AW - 3;
    localparam int CNT_W = 16 + $clog2(CYC_PER_US + 1);

    state_e             state, nxt;
    kind_e              kind;
    logic [ROM_AW-1:0]  ptr;
    logic [IDX_W-1:0]   remaining;
    logic [IDX_W-1:0]   entries_in;
    logic [31:0]        ofs_word;
    logic [31:0]        arg_word;
    logic [CNT_W-1:0]   wait_len;
    logic               tmr_load;
    logic               tmr_last;
    logic               done_q;
    logic               err_q;
    logic               size_unused;

    assign entries_in  = tbl_size[ROM_AW-1:3];
    assign size_unused = ^tbl_size[2:0];
    assign wait_len    = CNT_W'(rom_rdata[15:0]) * CNT_W'(CYC_PER_US);
    assign tmr_load    = (state == S_DECODE) && (kind == K_WAIT_US);

    init_seq_decode u_decode (
        .ofs_word (ofs_word),
        .kind     (kind)
    );

    init_seq_merge #(.DATA_W(DATA_W), .FIELD_W(16)) u_merge (
        .old_val (reg_rdata),
        .arg     (arg_word),
        .new_val (reg_wdata)
    );

    init_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (wait_len),
        .last     (tmr_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start && entries_in != '0) nxt = S_FETCH_OFS;
            S_FETCH_OFS: nxt = S_FETCH_ARG;
            S_FETCH_ARG: nxt = S_DECODE;
            S_DECODE: begin
                unique case (kind)
                    K_REG:      nxt = S_WRITE;
                    K_WAIT_US:  nxt = (wait_len == '0) ? S_ADVANCE : S_WAIT_US;
                    K_WAIT_RDY: nxt = S_WAIT_RDY;
                    K_UNKNOWN:  nxt = S_ADVANCE;
                endcase
            end
            S_WRITE:     nxt = S_ADVANCE;
            S_WAIT_US:   if (tmr_last) nxt = S_ADVANCE;
            S_WAIT_RDY:  if (mem_ready) nxt = S_ADVANCE;
            S_ADVANCE:   nxt = (remaining == IDX_W'(1)) ? S_IDLE : S_FETCH_OFS;
        endcase
    end

    // Sequence datapath and held flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            remaining <= '0;
            ofs_word  <= '0;
            arg_word  <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    ptr       <= tbl_offset;
                    remaining <= entries_in;
                    done_q    <= (entries_in == '0);
                    err_q     <= 1'b0;
                end
                S_FETCH_ARG: ofs_word <= rom_rdata;
                S_DECODE: begin
                    arg_word <= rom_rdata;
                    if (kind == K_UNKNOWN) err_q <= 1'b1;
                end
                S_ADVANCE: begin
                    ptr       <= ptr + ROM_AW'(8);
                    remaining <= remaining - IDX_W'(1);
                    if (remaining == IDX_W'(1)) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        rom_en   = (state == S_FETCH_OFS) || (state == S_FETCH_ARG);
        rom_addr = (state == S_FETCH_ARG) ? ptr + ROM_AW'(4) : ptr;
        reg_rd   = (state == S_DECODE) && (kind == K_REG);
        reg_wr   = (state == S_WRITE);
        reg_addr = ofs_word[ADDR_W-1:0];
        busy     = (state != S_IDLE);
        done     = done_q;
        err      = err_q;
    end
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk #(
    parameter int ROM_AW = 16,
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              rom_en,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr
);
    AST_ROM_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_en) |=> rom_en && (rom_addr == ROM_AW'($past(rom_addr) + ROM_AW'(4)))); // R1

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(reg_rd) && (reg_addr == $past(reg_addr))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rom_en && !reg_rd && !reg_wr); // R8

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R9

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R10

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err); // R7
endmodule

bind init_seq init_seq_chk #(.ROM_AW(ROM_AW), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rom_en   (rom_en),
    .rom_addr (rom_addr),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr)
);

// File: tb/init_seq_tb.sv
`timescale 1ns/1ps
module init_seq_tb;
    localparam int CLK_NS = 20;
    localparam int CPU    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tbl_offset = '0;
    logic [15:0] tbl_size = '0;
    logic        rom_en;
    logic [15:0] rom_addr;
    logic [31:0] rom_rdata = '0;
    logic        reg_rd, reg_wr;
    logic [16:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        mem_ready = 1'b1;
    logic        busy, done, err;

    logic [31:0] rom  [64];
    logic [31:0] regs [32];
    int rd_cnt = 0, wr_cnt = 0;
    int checks = 0, fails = 0;

    always #(CLK_NS/2) clk = ~clk;

    init_seq #(.CYC_PER_US(CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tbl_offset(tbl_offset), .tbl_size(tbl_size),
        .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .err(err)
    );

    // Memory and register response models
    always @(posedge clk) begin
        if (rom_en) rom_rdata <= rom[rom_addr[7:2]];
        if (reg_rd) begin
            reg_rdata <= regs[reg_addr[6:2]];
            rd_cnt <= rd_cnt + 1;
        end
        if (reg_wr) begin
            regs[reg_addr[6:2]] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // addr, initial register value, value, mask, expected result
    localparam logic [31:0] VEC [4][5] = '{
        '{32'h04, 32'hAAAA_5555, 32'h1234, 32'hFFFF, 32'hAAAA_1234},
        '{32'h08, 32'hFFFF_FFFF, 32'h0000, 32'h00FF, 32'hFFFF_FF00},
        '{32'h0C, 32'h1234_0000, 32'hFFFF, 32'h0F0F, 32'h1234_0F0F},
        '{32'h10, 32'h0000_ABCD, 32'h5A5A, 32'h0000, 32'h0000_ABCD}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input int word, input logic [31:0] ofs, input logic [31:0] arg);
        rom[word]   = ofs;
        rom[word+1] = arg;
    endtask

    task automatic pulse(input logic [15:0] ofs, input logic [15:0] sz);
        @(negedge clk);
        tbl_offset = ofs; tbl_size = sz; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [15:0] ofs, input logic [15:0] sz, output int cyc);
        pulse(ofs, sz);
        cyc = 0;
        rd_cnt = 0; wr_cnt = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < 64; i++) rom[i] = '0;
        for (int i = 0; i < 32; i++) regs[i] = '0;
        for (int i = 0; i < 4; i++) begin
            put(2*i, VEC[i][0], {VEC[i][3][15:0], VEC[i][2][15:0]});
            regs[VEC[i][0][6:2]] = VEC[i][1];
        end
        put(16, 32'h0002_0000, {16'hBEEF, 16'd3});
        put(18, 32'h14, {16'hFFFF, 16'h00C3});
        put(20, 32'h0002_0000, {16'hBEEF, 16'd0});
        put(22, 32'h18, {16'hFFFF, 16'h0011});
        put(24, 32'h0002_0001, 32'h0);
        put(26, 32'h1C, {16'hFFFF, 16'h0077});
        put(28, 32'h0002_0002, 32'hFFFF_FFFF);
        put(30, 32'h20, {16'hFFFF, 16'h0099});
        put(32, 32'h24, {16'hFFFF, 16'h0042});
        put(34, 32'h28, {16'hFFFF, 16'h0055});

        repeat (3) @(negedge clk);
        chk(!busy, "reset busy (R10)", 32'(busy), 0);
        chk(!done, "reset done (R10)", 32'(done), 0);
        chk(!err,  "reset err (R7)",   32'(err),  0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: vector table walked as one sequence
        run(16'h0000, 16'd32, cyc);
        chk(done, "vector run done (R1)", 32'(done), 1);
        chk(cyc == 20, "vector run busy cycles (R1)", cyc, 20);
        chk(rd_cnt == 4 && wr_cnt == 4, "vector run rmw count (R2)", wr_cnt, 4);
        for (int i = 0; i < 4; i++)
            chk(regs[VEC[i][0][6:2]] == VEC[i][4], "masked merge (R3 R4)",
                regs[VEC[i][0][6:2]], VEC[i][4]);

        // R10: done holds, then clears on start
        repeat (5) @(negedge clk);
        chk(done, "done held (R10)", 32'(done), 1);
        pulse(16'h0040, 16'd16);
        chk(!done && busy, "done cleared on start (R10)", 32'({busy, done}), 32'b10);
        while (busy) @(negedge clk);

        // R5: timed wait, upper operand ignored
        run(16'h0040, 16'd16, cyc);
        chk(cyc == 4 + 3*CPU + 5, "timed wait length (R5)", cyc, 4 + 3*CPU + 5);
        chk(regs[5] == 32'h0000_00C3, "write after wait (R5)", regs[5], 32'hC3);
        run(16'h0050, 16'd16, cyc);
        chk(cyc == 9, "zero wait immediate (R5)", cyc, 9);
        chk(regs[6] == 32'h0000_0011, "write after zero wait (R5)", regs[6], 32'h11);

        // R6 and R9: ready wait stalls; start while busy ignored
        mem_ready = 1'b0;
        pulse(16'h0060, 16'd16);
        rd_cnt = 0; wr_cnt = 0;
        repeat (20) @(negedge clk);
        chk(busy && wr_cnt == 0, "stall on not ready (R6)", wr_cnt, 0);
        pulse(16'h0080, 16'd0);
        @(negedge clk);
        chk(busy && !done, "start while busy ignored (R9)", 32'({busy, done}), 32'b10);
        mem_ready = 1'b1;
        cyc = 0;
        while (busy && cyc < 100) begin cyc++; @(negedge clk); end
        chk(done && regs[7] == 32'h77, "resume on ready (R6)", regs[7], 32'h77);
        chk(regs[9] == 32'h0, "ignored start ran nothing (R9)", regs[9], 0);

        // R7: unknown command skipped, error sticky until start
        run(16'h0070, 16'd16, cyc);
        chk(err, "unknown sets err (R7)", 32'(err), 1);
        chk(rd_cnt == 1 && wr_cnt == 1, "unknown no bus access (R7)", rd_cnt + wr_cnt, 2);
        chk(regs[0] == 32'h0 && regs[8] == 32'h99, "unknown skipped (R7)", regs[8], 32'h99);

        // R8: size zero gives done one cycle later; remainder ignored
        run(16'h0000, 16'd0, cyc);
        chk(done && cyc == 0, "size zero done next cycle (R8)", cyc, 0);
        chk(!err, "err cleared by start (R7)", 32'(err), 0);
        run(16'h0080, 16'd12, cyc);
        chk(wr_cnt == 1, "remainder ignored (R8)", wr_cnt, 1);
        chk(regs[9] == 32'h42 && regs[10] == 32'h0, "only whole entry ran (R8)", regs[10], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule